// File: doc/BRIEF.md
# Interrupt Pin Capture and Message Dispatcher

This block sits between a set of interrupt request lines and the memory-write path of a system interconnect. Each time an input line changes, the block receives an event that carries the pin number and its new level. The block keeps one pending bit for each pin. A change that can lead to delivery starts a service pass. The pass walks the pins from lowest to highest. Each pin that is pending, unmasked and deliverable becomes one message-signalled interrupt. That message is a 32-bit address and a 32-bit data word, offered on a valid/ready output. The output holds while the consumer stalls.

A separate register block owns the per-pin redirection entries. It feeds them in as one flat vector, 64 bits per pin. When a level-sensitive pin is delivered, this block returns a one-cycle request to set that pin's remote-IRR flag, and the register block applies it. A pin whose delivery mode selects the external legacy controller gets its vector from that controller through a request/acknowledge port before its message goes out.

Top module: `irq_msi_dispatch`

## Requirements
- R1: An event on pin number 0 acts on pin 2. Every other pin number below the pin count acts on itself. An event whose remapped pin number is at or above the pin count changes nothing and produces no message.
- R2: When a level pin (entry bit 15 = 1) is asserted while it is unmasked (entry bit 16 = 0) and its remote IRR (entry bit 14) is clear, exactly one message is sent for it.
- R3: A pending level pin whose remote IRR is set is skipped and sends no message. It stays pending, and it is delivered by a later pass once its remote IRR has been cleared.
- R4: Deasserting a level pin clears its pending bit, so a later pass sends nothing for it even after it is unmasked.
- R5: An asserted event on an edge pin (entry bit 15 = 0) that is masked is dropped. Unmasking the pin later does not deliver it.
- R6: Delivering an edge pin clears its pending bit, so the next pass does not send it again.
- R7: Within one pass, deliverable pins are sent in ascending pin order.
- R8: Each delivery of a level pin produces exactly one remote-IRR set request that carries the pin index. Edge deliveries produce none.
- R9: The message address is 0xFEE00000, ORed with the destination field (entry bits 63:48) shifted left by 12, ORed with the destination-mode bit (entry bit 11) shifted left by 2.
- R10: The message data holds the vector in bits 7:0, the delivery mode (entry bits 10:8) in bits 10:8, and the trigger bit in bit 15. All other data bits are zero. The vector is entry bits 7:0.
- R11: When the delivery mode is 3'b111, the vector comes from the legacy port instead of the entry. The request stays high until it is acknowledged.
- R12: While a message is valid and not accepted, the valid signal, the address and the data stay unchanged.
- R13: After reset, no message is valid, no legacy request is raised and no remote-IRR request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_evt_valid | input | 1 | A pin level change is presented this cycle |
| irq_evt_pin | input | PIN_W | Pin number of the event, before remapping |
| irq_evt_level | input | 1 | New level of that pin |
| rte_tbl | input | NUM_PINS*64 | Redirection entries, 64 bits per pin, pin 0 in the lowest bits |
| rirr_set_valid | output | 1 | Request to set remote IRR for one pin |
| rirr_set_idx | output | clog2(NUM_PINS) | Pin whose remote IRR is to be set |
| ext_vec_req | output | 1 | Vector request to the legacy controller |
| ext_vec_ack | input | 1 | Legacy controller supplies the vector this cycle |
| ext_vec_data | input | 8 | Vector from the legacy controller |
| msg_valid | output | 1 | Message is offered |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The dispatcher is driven with a single unmasked level pin and then with several level pins that are made pending while masked and released together. The first case confirms the message format. The second case shows that the scan order is ascending and independent of the order in which events arrived. Masked edge events, level deassertion before unmasking, and level assertion with remote IRR already set are each followed by a pass started from another pin. Comparing the messages of that pass separates "dropped", "cleared" and "held pending" from one another. Pin-0 remapping, out-of-range pin numbers, a legacy-vector fetch with a delayed acknowledge, and a stalled consumer cover the remaining paths.

// File: rtl/irq_msi_pkg.sv
// Package: shared constants and types for the interrupt dispatcher.
// Holds the bit positions inside a 64-bit redirection entry, the scan
// states and the captured message fields handed to the formatter.
package irq_msi_pkg;

    localparam int RTE_W     = 64;
    localparam int B_VEC_LO  = 0;
    localparam int B_DLV_LO  = 8;
    localparam int B_DMODE   = 11;
    localparam int B_RIRR    = 14;
    localparam int B_TRIG    = 15;
    localparam int B_MASK    = 16;
    localparam int B_DEST_LO = 48;

    localparam logic [2:0] DLV_LEGACY = 3'b111;
    localparam int         REMAP_SRC  = 0;
    localparam int         REMAP_DST  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FETCH = 2'd2,
        ST_SEND  = 2'd3
    } scan_st_e;

    typedef struct packed {
        logic [15:0] dest;
        logic        dst_mode;
        logic [2:0]  dlv;
        logic        trig;
        logic [7:0]  vec;
    } msg_fields_t;

endpackage

// File: rtl/irq_pin_capture.sv
// Module: per-pin pending register and pass trigger.
// Remaps the incoming pin number, drops out-of-range events, and applies
// the rules for level and edge pins to the pending bits. It raises a
// one-cycle kick when a service pass should run.
// Assumes at most one event per cycle. A set from an event wins over a
// clear from the scanner on the same pin in the same cycle.
module irq_pin_capture
    import irq_msi_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 8,
    localparam int IDX_W   = $clog2(NUM_PINS)
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      evt_valid,
    input  logic [PIN_W-1:0]          evt_pin,
    input  logic                      evt_level,
    input  logic [NUM_PINS*RTE_W-1:0] rte_tbl,
    input  logic                      clr_valid,
    input  logic [IDX_W-1:0]          clr_idx,
    output logic [NUM_PINS-1:0]       pending,
    output logic                      pass_kick
);

    logic [RTE_W-1:0] ent_arr [NUM_PINS];
    logic [PIN_W-1:0] map_pin;
    logic             in_range;
    logic [IDX_W-1:0] sel_idx;
    logic             ent_trig;
    logic             ent_mask;
    logic             ent_rirr;
    logic             set_hit;
    logic             drop_hit;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        assign ent_arr[g] = rte_tbl[g*RTE_W +: RTE_W];
    end

    // Remap the pin number, pick its entry and classify the event.
    always_comb begin
        map_pin   = (evt_pin == PIN_W'(REMAP_SRC)) ? PIN_W'(REMAP_DST) : evt_pin;
        in_range  = int'(map_pin) < NUM_PINS;
        sel_idx   = in_range ? map_pin[IDX_W-1:0] : '0;
        ent_trig  = ent_arr[sel_idx][B_TRIG];
        ent_mask  = ent_arr[sel_idx][B_MASK];
        ent_rirr  = ent_arr[sel_idx][B_RIRR];
        set_hit   = evt_valid && in_range && evt_level && (ent_trig || !ent_mask);
        drop_hit  = evt_valid && in_range && !evt_level && ent_trig;
        pass_kick = evt_valid && in_range && evt_level &&
                    (ent_trig ? !ent_rirr : !ent_mask);
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pend
        logic hit_here;
        assign hit_here = (sel_idx == IDX_W'(p));

        // Pending bit of one pin: an event set wins over any clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pending[p] <= 1'b0;
            end else if (set_hit && hit_here) begin
                pending[p] <= 1'b1;
            end else if ((drop_hit && hit_here) ||
                         (clr_valid && clr_idx == IDX_W'(p))) begin
                pending[p] <= 1'b0;
            end
        end
    end

    // An out-of-range pin number leaves every pending bit alone.
    p_oob_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !in_range && !clr_valid) |=> $stable(pending));

    // Deasserting a level pin leaves it not pending.
    p_level_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_hit) |=> !pending[$past(sel_idx)]);

    // A masked edge event on a pin that is not pending leaves it not pending.
    p_masked_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && in_range && evt_level && !ent_trig && ent_mask &&
         !pending[sel_idx]) |=> !pending[$past(sel_idx)]);

    // An edge delivery clears pending unless a new event lands on it.
    p_edge_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !(set_hit && sel_idx == clr_idx)) |=> !pending[$past(clr_idx)]);

endmodule

// File: rtl/irq_scan_fsm.sv
// Module: service-pass sequencer.
// Walks the pins in ascending order, one pin per cycle, and decides
// whether each pin is delivered. It requests pending-clear or remote-IRR
// set, fetches a legacy vector when needed, and holds the captured
// message until it is accepted.
// Assumes the register block applies a remote-IRR set by the next edge.
// A kick that arrives during a pass schedules one more pass.
module irq_scan_fsm
    import irq_msi_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = $clog2(NUM_PINS)
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pass_kick,
    input  logic [NUM_PINS-1:0]       pending,
    input  logic [NUM_PINS*RTE_W-1:0] rte_tbl,
    input  logic                      msg_ready,
    input  logic                      ext_vec_ack,
    input  logic [7:0]                ext_vec_data,
    output logic                      clr_valid,
    output logic [IDX_W-1:0]          clr_idx,
    output logic                      rirr_set_valid,
    output logic [IDX_W-1:0]          rirr_set_idx,
    output logic                      ext_vec_req,
    output logic                      msg_valid,
    output msg_fields_t               held
);

    logic [RTE_W-1:0] ent_arr [NUM_PINS];
    scan_st_e         state;
    logic [IDX_W-1:0] idx;
    logic             pass_req;
    logic             cur_trig;
    logic             cur_mask;
    logic             cur_rirr;
    logic             deliver;
    logic             last;
    msg_fields_t      cand;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        assign ent_arr[g] = rte_tbl[g*RTE_W +: RTE_W];
    end

    // Decode the entry under the scan pointer and judge deliverability.
    always_comb begin
        cur_trig      = ent_arr[idx][B_TRIG];
        cur_mask      = ent_arr[idx][B_MASK];
        cur_rirr      = ent_arr[idx][B_RIRR];
        cand.dest     = ent_arr[idx][B_DEST_LO +: 16];
        cand.dst_mode = ent_arr[idx][B_DMODE];
        cand.dlv      = ent_arr[idx][B_DLV_LO +: 3];
        cand.trig     = cur_trig;
        cand.vec      = ent_arr[idx][B_VEC_LO +: 8];
        deliver       = pending[idx] && !cur_mask && !(cur_trig && cur_rirr);
        last          = (idx == IDX_W'(NUM_PINS - 1));
    end

    // Side requests issued in the cycle a pin is chosen.
    always_comb begin
        clr_valid      = (state == ST_SCAN) && deliver && !cur_trig;
        clr_idx        = idx;
        rirr_set_valid = (state == ST_SCAN) && deliver && cur_trig;
        rirr_set_idx   = idx;
        ext_vec_req    = (state == ST_FETCH);
        msg_valid      = (state == ST_SEND);
    end

    // Sequencer: idle, step through pins, fetch a vector, offer a message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            pass_req <= 1'b0;
            held     <= '0;
        end else begin
            if (pass_kick) begin
                pass_req <= 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (pass_req || pass_kick) begin
                        state    <= ST_SCAN;
                        idx      <= '0;
                        pass_req <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (deliver) begin
                        held  <= cand;
                        state <= (cand.dlv == DLV_LEGACY) ? ST_FETCH : ST_SEND;
                    end else if (last) begin
                        state <= ST_IDLE;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_FETCH: begin
                    if (ext_vec_ack) begin
                        held.vec <= ext_vec_data;
                        state    <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (msg_ready) begin
                        if (last) begin
                            state <= ST_IDLE;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            state <= ST_SCAN;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A remote-IRR set is only requested for a pin whose flag is clear.
    p_coalesce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rirr_set_valid |-> !ent_arr[rirr_set_idx][B_RIRR]);

    // A pin that is not delivered moves the pointer up by one.
    p_scan_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && !deliver && !last) |=> (idx == $past(idx) + IDX_W'(1)));

    // The legacy request stays up until it is acknowledged.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_vec_req && !ext_vec_ack) |=> ext_vec_req);

    // A stalled message keeps its content.
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(held)));

endmodule

// File: rtl/irq_msg_format.sv
// Module: builds the message address and data words from captured fields.
// Purely combinational. It assumes its inputs are held steady by the
// sequencer for as long as the message is offered.
module irq_msg_format
    import irq_msi_pkg::*;
#(
    parameter logic [31:0] MSI_BASE  = 32'hFEE0_0000,
    parameter int          DEST_LSB  = 12,
    parameter int          DMODE_BIT = 2
)(
    input  msg_fields_t f,
    output logic [31:0] addr,
    output logic [31:0] data
);

    // Pack destination into the address, and vector, mode and trigger into the data.
    always_comb begin
        addr = MSI_BASE | (32'(f.dest) << DEST_LSB) | (32'(f.dst_mode) << DMODE_BIT);
        data = {16'h0000, f.trig, 4'b0000, f.dlv, f.vec};
    end

endmodule

// File: rtl/irq_msi_dispatch.sv
// Module: top of the interrupt pin capture and message dispatcher.
// Wires the pending register, the pass sequencer and the message
// formatter together. It assumes the redirection entries are owned and
// updated outside this block, including remote-IRR set requests.
module irq_msi_dispatch
    import irq_msi_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 8,
    localparam int IDX_W   = $clog2(NUM_PINS)
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      irq_evt_valid,
    input  logic [PIN_W-1:0]          irq_evt_pin,
    input  logic                      irq_evt_level,
    input  logic [NUM_PINS*64-1:0]    rte_tbl,
    output logic                      rirr_set_valid,
    output logic [IDX_W-1:0]          rirr_set_idx,
    output logic                      ext_vec_req,
    input  logic                      ext_vec_ack,
    input  logic [7:0]                ext_vec_data,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [31:0]               msg_addr,
    output logic [31:0]               msg_data
);

    logic [NUM_PINS-1:0] pending;
    logic                pass_kick;
    logic                clr_valid;
    logic [IDX_W-1:0]    clr_idx;
    msg_fields_t         held;

    irq_pin_capture #(
        .NUM_PINS (NUM_PINS),
        .PIN_W    (PIN_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (irq_evt_valid),
        .evt_pin   (irq_evt_pin),
        .evt_level (irq_evt_level),
        .rte_tbl   (rte_tbl),
        .clr_valid (clr_valid),
        .clr_idx   (clr_idx),
        .pending   (pending),
        .pass_kick (pass_kick)
    );

    irq_scan_fsm #(
        .NUM_PINS (NUM_PINS)
    ) u_scan (
        .clk            (clk),
        .rst_n          (rst_n),
        .pass_kick      (pass_kick),
        .pending        (pending),
        .rte_tbl        (rte_tbl),
        .msg_ready      (msg_ready),
        .ext_vec_ack    (ext_vec_ack),
        .ext_vec_data   (ext_vec_data),
        .clr_valid      (clr_valid),
        .clr_idx        (clr_idx),
        .rirr_set_valid (rirr_set_valid),
        .rirr_set_idx   (rirr_set_idx),
        .ext_vec_req    (ext_vec_req),
        .msg_valid      (msg_valid),
        .held           (held)
    );

    irq_msg_format u_format (
        .f    (held),
        .addr (msg_addr),
        .data (msg_data)
    );

endmodule

// File: tb/sim_irq_msi_dispatch.sv
// Scoreboard bench: stimulus pushes expected messages into a queue, and a
// monitor pops and compares them when the design hands a message over.
module sim_irq_msi_dispatch;

    localparam int NP = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ev_valid = 1'b0;
    logic [7:0]       ev_pin = '0;
    logic             ev_level = 1'b0;
    logic [NP*64-1:0] rte_tbl;
    logic             rirr_set_valid;
    logic [4:0]       rirr_set_idx;
    logic             ext_vec_req;
    logic             ext_vec_ack = 1'b0;
    logic [7:0]       ext_vec_data = '0;
    logic             msg_valid;
    logic             rdy = 1'b1;
    logic [31:0]      msg_addr;
    logic [31:0]      msg_data;

    logic [63:0]      tbl [NP];
    int               upd_cnt [NP];
    int               n_chk = 0;
    int               n_err = 0;
    bit               done = 0;
    int               req_cycles = 0;
    string            cur_tag = "R13";
    logic [31:0]      exp_a [$];
    logic [31:0]      exp_d [$];
    string            exp_t [$];

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) rte_tbl[i*64 +: 64] = tbl[i];
    end

    irq_msi_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .irq_evt_valid(ev_valid), .irq_evt_pin(ev_pin),
        .irq_evt_level(ev_level), .rte_tbl(rte_tbl), .rirr_set_valid(rirr_set_valid),
        .rirr_set_idx(rirr_set_idx), .ext_vec_req(ext_vec_req), .ext_vec_ack(ext_vec_ack),
        .ext_vec_data(ext_vec_data), .msg_valid(msg_valid), .msg_ready(rdy),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // Register-block model: apply remote-IRR set requests and count them.
    always @(posedge clk) begin
        if (rst_n && rirr_set_valid) begin
            tbl[rirr_set_idx][14] <= 1'b1;
            upd_cnt[rirr_set_idx] <= upd_cnt[rirr_set_idx] + 1;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(logic [7:0] vec, logic [2:0] dlv, logic dm,
                                       logic trig, logic msk, logic [15:0] dest);
        logic [63:0] e = '0;
        e[7:0] = vec; e[10:8] = dlv; e[11] = dm; e[15] = trig; e[16] = msk;
        e[63:48] = dest;
        return e;
    endfunction

    task automatic push_exp(int pin, logic [7:0] vec, string tag);
        logic [63:0] e = tbl[pin];
        exp_a.push_back(32'hFEE0_0000 | ({16'h0, e[63:48]} << 12) | (32'(e[11]) << 2));
        exp_d.push_back({16'h0, e[15], 4'b0, e[10:8], vec});
        exp_t.push_back(tag);
    endtask

    task automatic ev(int pin, logic lvl);
        @(posedge clk); #1;
        ev_valid = 1'b1; ev_pin = 8'(pin); ev_level = lvl;
        @(posedge clk); #1;
        ev_valid = 1'b0;
    endtask

    task automatic set_ent(int pin, logic [63:0] e);
        @(posedge clk); #1;
        tbl[pin] = e;
    endtask

    task automatic settle(string tag);
        repeat (80) @(negedge clk);
        chk({tag, " queue drained"}, 64'(exp_a.size()), 64'd0);
        exp_a.delete(); exp_d.delete(); exp_t.delete();
    endtask

    // Monitor: compare each accepted message with the head of the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && msg_valid && rdy) begin
                if (exp_a.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL %s unexpected message act=%h_%h exp=none",
                             cur_tag, msg_addr, msg_data);
                end else begin
                    chk(exp_t[0], {msg_addr, msg_data}, {exp_a[0], exp_d[0]});
                    void'(exp_a.pop_front()); void'(exp_d.pop_front());
                    void'(exp_t.pop_front());
                end
            end
        end
    end

    // Legacy controller model: answer a vector request after three cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (ext_vec_req) begin
                req_cycles = 1;
                repeat (3) begin
                    @(negedge clk);
                    if (ext_vec_req) req_cycles++;
                end
                @(posedge clk); #1;
                ext_vec_ack = 1'b1; ext_vec_data = 8'h5A;
                @(posedge clk); #1;
                ext_vec_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R13 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold_a, hold_d;
        for (int i = 0; i < NP; i++) begin
            tbl[i] = mk(8'(8'h20 + i), 3'd0, 1'b0, 1'b0, 1'b1, 16'(i));
            upd_cnt[i] = 0;
        end
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R13: idle outputs after reset
        chk("R13 msg_valid", 64'(msg_valid), 64'd0);
        chk("R13 ext_vec_req", 64'(ext_vec_req), 64'd0);
        chk("R13 rirr_set_valid", 64'(rirr_set_valid), 64'd0);

        // R2 R9 R10: single unmasked level pin
        cur_tag = "R2";
        set_ent(4, mk(8'h41, 3'd1, 1'b1, 1'b1, 1'b0, 16'h00AB));
        push_exp(4, 8'h41, "R2/R9/R10 level pin 4");
        ev(4, 1'b1);
        settle("R2");
        chk("R8 one rirr update for pin 4", 64'(upd_cnt[4]), 64'd1);
        ev(4, 1'b0);

        // R3: coalesce while remote IRR set, deliver after it clears
        cur_tag = "R3";
        set_ent(9, mk(8'h49, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0009));
        ev(4, 1'b1);
        push_exp(9, 8'h49, "R3 only pin 9 while pin 4 coalesced");
        ev(9, 1'b1);
        settle("R3");
        @(posedge clk); #1 tbl[4][14] = 1'b0;
        push_exp(4, 8'h41, "R3 pin 4 after remote IRR cleared");
        push_exp(9, 8'h49, "R3/R7 pin 9 after pin 4");
        ev(9, 1'b1);
        settle("R3");
        chk("R8 pin 4 updated twice", 64'(upd_cnt[4]), 64'd2);
        chk("R8 edge pin 9 no update", 64'(upd_cnt[9]), 64'd0);
        ev(4, 1'b0);

        // R6: delivered edge pin is not repeated
        cur_tag = "R6";
        set_ent(10, mk(8'h4A, 3'd0, 1'b0, 1'b0, 1'b0, 16'h000A));
        push_exp(10, 8'h4A, "R6 only pin 10, pin 9 not repeated");
        ev(10, 1'b1);
        settle("R6");

        // R5: masked edge is dropped
        cur_tag = "R5";
        ev(12, 1'b1);
        set_ent(12, mk(8'h4C, 3'd0, 1'b0, 1'b0, 1'b0, 16'h000C));
        push_exp(10, 8'h4A, "R5 only pin 10, masked edge on 12 dropped");
        ev(10, 1'b1);
        settle("R5");

        // R4: level deasserted before unmask is not sent; held level is sent
        cur_tag = "R4";
        set_ent(14, mk(8'h4E, 3'd0, 1'b0, 1'b1, 1'b1, 16'h000E));
        set_ent(15, mk(8'h4F, 3'd0, 1'b0, 1'b1, 1'b1, 16'h000F));
        ev(14, 1'b1);
        ev(14, 1'b0);
        ev(15, 1'b1);
        settle("R4");
        @(posedge clk); #1 tbl[14][16] = 1'b0; tbl[15][16] = 1'b0;
        push_exp(10, 8'h4A, "R4 pin 10");
        push_exp(15, 8'h4F, "R4 held level pin 15, not 14");
        ev(10, 1'b1);
        settle("R4");
        ev(15, 1'b0);

        // R1: pin 0 acts on pin 2; out-of-range numbers ignored
        cur_tag = "R1";
        set_ent(0, mk(8'h60, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000));
        set_ent(2, mk(8'h62, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0002));
        push_exp(2, 8'h62, "R1 pin 0 remapped to 2");
        ev(0, 1'b1);
        settle("R1");
        ev(24, 1'b1);
        ev(30, 1'b1);
        settle("R1 out of range");

        // R7: ascending order regardless of arrival order
        cur_tag = "R7";
        set_ent(20, mk(8'h54, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0014));
        set_ent(6,  mk(8'h46, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0006));
        set_ent(17, mk(8'h51, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0011));
        ev(20, 1'b1); ev(6, 1'b1); ev(17, 1'b1);
        settle("R7 masked");
        @(posedge clk); #1 tbl[20][16] = 1'b0; tbl[6][16] = 1'b0; tbl[17][16] = 1'b0;
        set_ent(1, mk(8'h31, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0001));
        push_exp(1, 8'h31, "R7 first pin 1");
        push_exp(6, 8'h46, "R7 second pin 6");
        push_exp(17, 8'h51, "R7 third pin 17");
        push_exp(20, 8'h54, "R7 fourth pin 20");
        ev(1, 1'b1);
        settle("R7");
        ev(20, 1'b0); ev(6, 1'b0); ev(17, 1'b0);

        // R11: legacy vector fetch
        cur_tag = "R11";
        set_ent(7, mk(8'h11, 3'b111, 1'b0, 1'b0, 1'b0, 16'h0007));
        push_exp(7, 8'h5A, "R11 vector from legacy port");
        ev(7, 1'b1);
        settle("R11");
        chk("R11 request held until ack", 64'(req_cycles), 64'd4);

        // R12: stalled output holds
        cur_tag = "R12";
        @(posedge clk); #1 rdy = 1'b0;
        set_ent(8, mk(8'h48, 3'd2, 1'b1, 1'b0, 1'b0, 16'h0108));
        push_exp(8, 8'h48, "R12 message after stall");
        ev(8, 1'b1);
        repeat (40) @(negedge clk);
        chk("R12 valid while stalled", 64'(msg_valid), 64'd1);
        hold_a = msg_addr; hold_d = msg_data;
        repeat (6) @(negedge clk);
        chk("R12 payload stable", {msg_addr, msg_data}, {hold_a, hold_d});
        chk("R12 still valid", 64'(msg_valid), 64'd1);
        @(posedge clk); #1 rdy = 1'b1;
        settle("R12");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule